// File: doc/BRIEF.md
# Serial EEPROM Word-Array Model with Three-Wire Command Port

This block stands in for a small serial EEPROM holding 16-bit words. A host drives a chip-select line, a serial clock and a serial data input. It reads results and status on a serial data output. Every command begins with a start bit of 1 while chip select is high. A two-bit opcode follows, then an address sent MSB first. Some commands also take a 16-bit data word. The model decodes the command and acts on an internal word array: it reads a word back, writes or erases one word, fills the whole array, or sets the program-enable latch. For opcode 00 the real command comes from the two top address bits.

The serial lines are sampled on a fast system clock. A low-to-high change of the serial clock counts as one serial edge. After a write or erase, the model holds an internal busy period of `PROG_CYCLES` serial edges. The host sees that period when it drops chip select and raises it again: data out reads 0 until the period ends, then 1. The `WIDE_ADDR` parameter selects either 6 address bits (64 words) or 8 address bits (256 words).

Top module: `uwire_eeprom`

## Requirements
- R1: After reset every word holds 16'hFFFF, programming is disabled and data out is 1.
- R2: While chip select is low, data out is 1. Any command in progress is dropped, and the block waits for a new start bit.
- R3: Opcode 10 reads a word. The address is 6 bits when WIDE_ADDR=0 and 8 bits when WIDE_ADDR=1, sent MSB first. The serial edge that shifts in the last address bit drives a 0 on data out. The next 16 serial edges then drive the word MSB first. The edge after that returns data out to 1.
- R4: Opcode 01 writes a word: the address, then 16 data bits MSB first, stored at the addressed word.
- R5: Opcode 11 erases the addressed word to 16'hFFFF.
- R6: Opcode 00 with top address bits 11 enables programming. Opcode 00 with top address bits 00 disables it. The lower address bits are ignored.
- R7: Opcode 00 with top address bits 10 sets every word to 16'hFFFF.
- R8: Opcode 00 with top address bits 01, followed by 16 data bits, writes that value to every word.
- R9: While programming is disabled, write, erase, erase-all and write-all leave the array unchanged and start no busy period.
- R10: After a programming command, chip select goes low and then high again. Data out then reads 0 until PROG_CYCLES serial edges have arrived with chip select high, and reads 1 after that. Start bits sent during the busy period are ignored.
- R11: Zero bits sent before the start bit are ignored. Bits sent after a command has finished are ignored until chip select goes low.
- R12: If chip select drops before a command is complete, the command has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; each rising transition is one serial edge |
| di | input | 1 | Serial command, address and data input |
| dout | output | 1 | Serial read data and ready/busy status; 1 when idle |

## Verification
The assertions check, on every cycle, the rules that tie the ports to the control state:
- data out is 1 whenever chip select is low, and the block is back in idle one cycle after a deselect;
- a busy period never starts while programming is disabled;
- a busy period ends only on a serial edge with chip select high after a reselect;
- read data holds steady between serial edges;
- no start bit is accepted during a busy period.

The stored contents need the bench's scenarios. These are the value written, erased or filled into each word, the leading zero and bit order of a read, and the fact that disabled or aborted commands leave words unchanged. Each of these is visible only by a later read.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter bit WIDE_ADDR   = 1'b0,
  parameter int PROG_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  localparam int AW    = WIDE_ADDR ? 8 : 6;
  localparam int DEPTH = 1 << AW;
  localparam int HW    = AW + 2;
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE = 3'd0, S_HDR = 3'd1, S_DAT = 3'd2,
                            S_RD = 3'd3, S_DONE = 3'd4} st_t;

  st_t            st;
  logic           sk_q, en, busy, armed, fill, rd_bit;
  logic [CW-1:0]  left;
  logic [4:0]     bits;
  logic [HW-1:0]  hdr;
  logic [15:0]    dat, rd_sh;
  logic [AW-1:0]  adr;
  logic [15:0]    mem [DEPTH];

  wire           rise   = sk & ~sk_q;
  wire [HW-1:0]  hdr_nx = {hdr[HW-2:0], di};
  wire [1:0]     op     = hdr_nx[HW-1:HW-2];
  wire [AW-1:0]  a_nx   = hdr_nx[AW-1:0];
  wire [1:0]     ext    = a_nx[AW-1:AW-2];
  wire [15:0]    dat_nx = {dat[14:0], di};

  assign dout = !cs ? 1'b1 :
                (st == S_RD) ? rd_bit :
                (busy && armed) ? 1'b0 : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sk_q   <= 1'b0;
      en     <= 1'b0;
      busy   <= 1'b0;
      armed  <= 1'b0;
      fill   <= 1'b0;
      rd_bit <= 1'b1;
      left   <= '0;
      bits   <= '0;
      hdr    <= '0;
      dat    <= '0;
      rd_sh  <= '0;
      adr    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else begin
      sk_q <= sk;
      if (!cs) begin
        st <= S_IDLE;
        if (busy) armed <= 1'b1;
      end else if (rise) begin
        if (busy && armed) begin
          left <= left - 1'b1;
          if (left == CW'(1)) begin
            busy  <= 1'b0;
            armed <= 1'b0;
          end
        end
        case (st)
          S_IDLE: if (!busy && di) begin
            st   <= S_HDR;
            bits <= '0;
            hdr  <= '0;
          end
          S_HDR: begin
            hdr  <= hdr_nx;
            bits <= bits + 1'b1;
            if (bits == 5'(HW - 1)) begin
              bits <= '0;
              adr  <= a_nx;
              fill <= 1'b0;
              st   <= S_DONE;
              case (op)
                2'b10: begin
                  st     <= S_RD;
                  rd_bit <= 1'b0;
                  rd_sh  <= mem[a_nx];
                end
                2'b01: st <= S_DAT;
                2'b11: if (en) begin
                  mem[a_nx] <= 16'hFFFF;
                  busy      <= 1'b1;
                  armed     <= 1'b0;
                  left      <= CW'(PROG_CYCLES);
                end
                default: case (ext)
                  2'b11: en <= 1'b1;
                  2'b00: en <= 1'b0;
                  2'b10: if (en) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
                    busy  <= 1'b1;
                    armed <= 1'b0;
                    left  <= CW'(PROG_CYCLES);
                  end
                  default: begin
                    st   <= S_DAT;
                    fill <= 1'b1;
                  end
                endcase
              endcase
            end
          end
          S_DAT: begin
            dat  <= dat_nx;
            bits <= bits + 1'b1;
            if (bits == 5'd15) begin
              st <= S_DONE;
              if (en) begin
                if (fill) begin
                  for (int i = 0; i < DEPTH; i++) mem[i] <= dat_nx;
                end else begin
                  mem[adr] <= dat_nx;
                end
                busy  <= 1'b1;
                armed <= 1'b0;
                left  <= CW'(PROG_CYCLES);
              end
            end
          end
          S_RD: begin
            if (bits == 5'd16) begin
              st     <= S_DONE;
              rd_bit <= 1'b1;
            end else begin
              rd_bit <= rd_sh[15];
              rd_sh  <= {rd_sh[14:0], 1'b0};
              bits   <= bits + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module uwire_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       sk,
  input logic       sk_q,
  input logic       dout,
  input logic [2:0] st,
  input logic       busy,
  input logic       armed,
  input logic       en
);
  assert_deselect_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> dout);
  assert_deselect_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (st == 3'd0));
  assert_busy_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> en);
  assert_busy_ends_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(armed && cs && sk && !sk_q));
  assert_no_start_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == 3'd0) |=> (st != 3'd1));
  assert_read_bit_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && cs && !(sk && !sk_q)) |=> (!cs || $stable(dout)));
endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .sk_q(sk_q), .dout(dout),
  .st(st), .busy(busy), .armed(armed), .en(en)
);

// File: tb/sim_uwire_eeprom.sv
`timescale 1ns/1ps
module sim_uwire_eeprom;
  localparam int AW = 6;
  localparam int WC = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;
  logic exp_dout = 1'b1;
  string cur_req = "R1";
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [15:0] ref_mem [64];
  bit ref_en = 1'b0;
  int ref_left = 0;
  bit ref_armed = 1'b0;

  uwire_eeprom #(.WIDE_ADDR(1'b0), .PROG_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (!finished) begin
      n_cmp++;
      if (dout !== exp_dout) begin
        n_bad++;
        $display("FAIL %s: dout=%b expected %b at %0t", cur_req, dout, exp_dout, $time);
      end
    end
  end

  task automatic serial_bit(input bit b, input bit e);
    @(negedge clk) di = b;
    @(negedge clk) begin sk = 1'b1; exp_dout = e; end
    @(negedge clk);
    @(negedge clk) sk = 1'b0;
  endtask

  task automatic deselect();
    @(negedge clk) begin cs = 1'b0; di = 1'b0; exp_dout = 1'b1; end
    if (ref_left > 0) ref_armed = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic start_busy();
    ref_left = WC;
    ref_armed = 1'b0;
  endtask

  task automatic cmd(input int op, input int addr, input logic [15:0] data,
                     input int lead0, input int cut);
    bit q[$];
    int n = 0;
    bit is_rd = (op == 2);
    bit has_dat = (op == 1) || (op == 0 && ((addr >> (AW-2)) & 3) == 1);
    logic [15:0] w;
    @(negedge clk) begin cs = 1'b1; exp_dout = 1'b1; end
    for (int i = 0; i < lead0; i++) q.push_back(1'b0);
    q.push_back(1'b1);
    q.push_back(op[1]);
    q.push_back(op[0]);
    for (int i = AW-1; i >= 0; i--) q.push_back(addr[i]);
    if (has_dat) for (int i = 15; i >= 0; i--) q.push_back(data[i]);
    foreach (q[i]) begin
      if (cut >= 0 && n >= cut) break;
      serial_bit(q[i], (is_rd && i == lead0 + AW + 2) ? 1'b0 : 1'b1);
      n++;
    end
    if (cut >= 0) begin
      deselect();
      return;
    end
    if (is_rd) begin
      w = ref_mem[addr];
      for (int i = 15; i >= 0; i--) serial_bit(1'b0, w[i]);
      serial_bit(1'b1, 1'b1);
      serial_bit(1'b1, 1'b1);
    end else if (op == 1) begin
      if (ref_en) begin ref_mem[addr] = data; start_busy(); end
    end else if (op == 3) begin
      if (ref_en) begin ref_mem[addr] = 16'hFFFF; start_busy(); end
    end else begin
      case ((addr >> (AW-2)) & 3)
        3: ref_en = 1'b1;
        0: ref_en = 1'b0;
        2: if (ref_en) begin
             foreach (ref_mem[i]) ref_mem[i] = 16'hFFFF;
             start_busy();
           end
        default: if (ref_en) begin
             foreach (ref_mem[i]) ref_mem[i] = data;
             start_busy();
           end
      endcase
    end
    deselect();
  endtask

  task automatic poll();
    @(negedge clk) begin cs = 1'b1; exp_dout = (ref_left > 0 && ref_armed) ? 1'b0 : 1'b1; end
    @(negedge clk);
    while (ref_left > 0) begin
      ref_left--;
      serial_bit(1'b1, (ref_left == 0) ? 1'b1 : 1'b0);
    end
    ref_armed = 1'b0;
    deselect();
  endtask

  task automatic rd(input int addr, input string r);
    cur_req = r;
    cmd(2, addr, 16'h0, 0, -1);
  endtask

  initial begin
    foreach (ref_mem[i]) ref_mem[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(5, "R1");
    rd(63, "R1");
    cur_req = "R9";
    cmd(1, 5, 16'h1234, 0, -1);
    poll();
    rd(5, "R9");
    cur_req = "R6";
    cmd(0, 6'b110000, 16'h0, 0, -1);
    cur_req = "R4";
    cmd(1, 5, 16'hA5C3, 0, -1);
    cur_req = "R10";
    poll();
    rd(5, "R3");
    cur_req = "R4";
    cmd(1, 63, 16'h1234, 0, -1);
    cur_req = "R10";
    poll();
    rd(63, "R4");
    rd(0, "R3");
    cur_req = "R5";
    cmd(3, 5, 16'h0, 0, -1);
    poll();
    rd(5, "R5");
    cur_req = "R12";
    cmd(1, 7, 16'h0F0F, 0, -1);
    poll();
    cmd(1, 7, 16'h5555, 0, 14);
    rd(7, "R12");
    cur_req = "R11";
    cmd(2, 7, 16'h0, 3, -1);
    cur_req = "R2";
    cmd(2, 63, 16'h0, 0, 5);
    rd(63, "R2");
    cur_req = "R8";
    cmd(0, 6'b010101, 16'hBEEF, 0, -1);
    poll();
    rd(0, "R8");
    rd(63, "R8");
    rd(21, "R8");
    cur_req = "R7";
    cmd(0, 6'b100011, 16'h0, 0, -1);
    poll();
    rd(0, "R7");
    rd(40, "R7");
    cur_req = "R6";
    cmd(0, 6'b001111, 16'h0, 0, -1);
    cur_req = "R9";
    cmd(1, 3, 16'h0000, 0, -1);
    poll();
    cmd(0, 6'b100000, 16'h0, 0, -1);
    rd(3, "R9");
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule